// File: doc/BRIEF.md
# Strip Cluster Finder

This block turns one digitised sensor frame into a short list of particle clusters. A frame is 128 adjacent strip channels. Each channel carries a 2-bit amplitude class. A pulse on `frame_start` loads `frame_data` into the block. The block then walks the channels in order and grows runs of neighbouring hit channels. Each run is judged by a three-level class rule combined with a summed-weight test. Every accepted cluster goes out as one record, which holds a sub-channel position, a member count and a few flags.

The weight given to each amplitude class is programmable. These weights feed both the summed-amplitude test and the weighted-mean position. Records leave in channel order through a valid/ready output. A frame tag ties every record to the frame it came from. A cap on records per frame bounds the output bandwidth. Any loss caused by the cap is flagged on the last record of that frame.

Top module: `cluster_finder`

## Requirements
- R1: After reset, `busy` and `out_valid` are both 0.
- R2: Channel i is `frame_data[2i+1:2i]`. Code 00 means no hit, 01 neighbour level, 10 seed level and 11 high level. A maximal run of adjacent non-zero channels forms one candidate. A frame with no accepted candidate emits no record.
- R3: A candidate that contains a high channel is accepted with no other condition. A candidate without one is accepted only when it contains a seed and the sum of its class weights (`cfg_w_nbr`, `cfg_w_seed`, `cfg_w_high`) is strictly greater than `cfg_sum_thr`. All other candidates are dropped, including runs made only of neighbour-level channels.
- R4: Channels 0 and 127 have no neighbours outside the frame. A run that reaches channel 127 is closed at the end of the frame.
- R5: `out_pos` equals floor(4·Σ(w·index)/Σw), which is the channel index with 2 fractional bits. When Σw is 0, `out_pos` is 4 times the index of the first member.
- R6: `out_size` is the member count, from 1 to 4. A run longer than 4 is cut into consecutive chunks of 4, and the remainder forms a final chunk. Every chunk is judged on its own. Each chunk except the final one has `out_split` = 1.
- R7: At most 16 records leave per frame, in ascending channel order. Accepted clusters beyond the 16th are dropped. The last record of a frame has `out_last` = 1, and it has `out_trunc` = 1 exactly when a cluster of that frame was dropped by the cap.
- R8: Each accepted frame receives a tag that starts at 0 and rises by 1 per frame, modulo 256. Every record of that frame carries the tag on `out_frame`.
- R9: While `busy` is 1, `frame_start` and `frame_data` are ignored. The frame being scanned and the tag sequence stay unchanged.
- R10: While `out_valid` is 1 and `out_ready` is 0, the record holds steady. No record is lost or repeated under back-pressure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Load `frame_data` and start a scan (only when idle) |
| frame_data | input | 256 | 128 channels × 2-bit amplitude class |
| cfg_w_nbr | input | 4 | Weight of a neighbour-level channel |
| cfg_w_seed | input | 4 | Weight of a seed-level channel |
| cfg_w_high | input | 4 | Weight of a high-level channel |
| cfg_sum_thr | input | 8 | Summed-weight threshold (strictly exceeded) |
| busy | output | 1 | A frame is being scanned or flushed |
| out_valid | output | 1 | A record is presented |
| out_ready | input | 1 | Downstream accepts the record |
| out_pos | output | 9 | Weighted-mean position, 2 fractional bits |
| out_size | output | 3 | Member count of the cluster |
| out_split | output | 1 | This chunk was cut from a longer run |
| out_last | output | 1 | Final record of the frame |
| out_trunc | output | 1 | Clusters of this frame were dropped by the cap |
| out_frame | output | 8 | Tag of the frame |

## Verification
The hardest condition to reach from the ports is the record cap together with output stalls. Here the 16th record must wait inside the block until the scan finishes, and only then can it learn that it is last and whether later clusters were dropped. The bench reaches this in two ways. It uses directed frames with 64 and with exactly 16 isolated high-level channels. It also sweeps dense pseudo-random frames under random weights and thresholds while `out_ready` is toggled pseudo-randomly. In both cases every record is compared against a cluster list that the bench computes arithmetically from the channel codes.

// File: rtl/cf_pkg.sv
package cf_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SCAN  = 2'd1,
    ST_FLUSH = 2'd2
  } cf_state_e;

  localparam logic [1:0] CODE_NONE = 2'b00;
  localparam logic [1:0] CODE_NBR  = 2'b01;
  localparam logic [1:0] CODE_SEED = 2'b10;
  localparam logic [1:0] CODE_HIGH = 2'b11;

  // Fractional offset of the weighted mean inside a chunk, in quarter channels.
  // wk_sum: sum of weight * offset-from-chunk-start, w_sum: sum of weights.
  function automatic logic [15:0] cf_centroid(logic [15:0] wk_sum, logic [15:0] w_sum);
    logic [17:0] num;
    num = {wk_sum, 2'b00};
    if (w_sum == 16'd0) return 16'd0;
    return 16'(num / {2'b00, w_sum});
  endfunction

endpackage

// File: rtl/cf_frame_store.sv
module cf_frame_store #(
  parameter int NCH   = 128,
  parameter int IDX_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [2*NCH-1:0]     din,
  input  logic [IDX_W-1:0]     rd_idx,
  output logic [1:0]           rd_code
);
  logic [2*NCH-1:0] data_q;
  logic [1:0]       ch [NCH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    data_q <= '0;
    else if (load) data_q <= din;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign ch[g] = data_q[2*g +: 2];
  end

  // Index NCH reads as an empty channel: closes any run at the frame edge.
  always_comb begin
    rd_code = cf_pkg::CODE_NONE;
    for (int i = 0; i < NCH; i++)
      if (rd_idx == IDX_W'(i)) rd_code = ch[i];
  end
endmodule

// File: rtl/cf_run_accum.sv
module cf_run_accum #(
  parameter int IDX_W    = 8,
  parameter int WGT_W    = 4,
  parameter int MAX_SIZE = 4,
  parameter int LEN_W    = 3,
  parameter int SW_W     = 7,
  parameter int SWK_W    = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [1:0]       code,
  input  logic [IDX_W-1:0] idx,
  input  logic [WGT_W-1:0] w_nbr,
  input  logic [WGT_W-1:0] w_seed,
  input  logic [WGT_W-1:0] w_high,
  output logic             close,
  output logic             split,
  output logic [IDX_W-1:0] c_start,
  output logic [LEN_W-1:0] c_len,
  output logic [SW_W-1:0]  c_sumw,
  output logic [SWK_W-1:0] c_sumwk,
  output logic             c_seed,
  output logic             c_high
);
  logic             hit;
  logic             full;
  logic [WGT_W-1:0] w;

  always_comb begin
    unique case (code)
      cf_pkg::CODE_NBR:  w = w_nbr;
      cf_pkg::CODE_SEED: w = w_seed;
      cf_pkg::CODE_HIGH: w = w_high;
      default:           w = '0;
    endcase
  end

  assign hit   = (code != cf_pkg::CODE_NONE);
  assign full  = (c_len == LEN_W'(MAX_SIZE));
  assign close = step && (c_len != '0) && (!hit || full);
  assign split = full && hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_start <= '0;
      c_len   <= '0;
      c_sumw  <= '0;
      c_sumwk <= '0;
      c_seed  <= 1'b0;
      c_high  <= 1'b0;
    end else if (step) begin
      if (!hit) begin
        c_len <= '0;
      end else if (c_len == '0 || full) begin
        c_start <= idx;
        c_len   <= LEN_W'(1);
        c_sumw  <= SW_W'(w);
        c_sumwk <= '0;
        c_seed  <= code[1];
        c_high  <= (code == cf_pkg::CODE_HIGH);
      end else begin
        c_len   <= c_len + LEN_W'(1);
        c_sumw  <= c_sumw + SW_W'(w);
        c_sumwk <= c_sumwk + SWK_W'(w) * SWK_W'(c_len);
        c_seed  <= c_seed | code[1];
        c_high  <= c_high | (code == cf_pkg::CODE_HIGH);
      end
    end
  end
endmodule

// File: rtl/cf_judge.sv
module cf_judge #(
  parameter int CH_W  = 7,
  parameter int IDX_W = 8,
  parameter int SW_W  = 7,
  parameter int SWK_W = 10,
  parameter int THR_W = 8,
  parameter int POS_W = 9
) (
  input  logic [IDX_W-1:0] c_start,
  input  logic [SW_W-1:0]  c_sumw,
  input  logic [SWK_W-1:0] c_sumwk,
  input  logic             c_seed,
  input  logic             c_high,
  input  logic [THR_W-1:0] thr,
  output logic             accept,
  output logic [POS_W-1:0] pos
);
  localparam int CMP_W = (SW_W > THR_W) ? SW_W : THR_W;

  logic        over_thr;
  logic [15:0] frac;

  assign over_thr = CMP_W'(c_sumw) > CMP_W'(thr);
  assign accept   = c_high || (c_seed && over_thr);
  assign frac     = cf_pkg::cf_centroid(16'(c_sumwk), 16'(c_sumw));
  assign pos      = {c_start[CH_W-1:0], 2'b00} + POS_W'(frac);
endmodule

// File: rtl/cluster_finder.sv
module cluster_finder #(
  parameter int NCH      = 128,
  parameter int WGT_W    = 4,
  parameter int THR_W    = 8,
  parameter int MAX_SIZE = 4,
  parameter int MAX_CL   = 16,
  parameter int TAG_W    = 8,
  localparam int CH_W    = $clog2(NCH),
  localparam int IDX_W   = $clog2(NCH + 1),
  localparam int LEN_W   = $clog2(MAX_SIZE + 1),
  localparam int POS_W   = CH_W + 2,
  localparam int CNT_W   = $clog2(MAX_CL + 1),
  localparam int SW_W    = WGT_W + LEN_W,
  localparam int SWK_W   = WGT_W + 2 * LEN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic [2*NCH-1:0] frame_data,
  input  logic [WGT_W-1:0] cfg_w_nbr,
  input  logic [WGT_W-1:0] cfg_w_seed,
  input  logic [WGT_W-1:0] cfg_w_high,
  input  logic [THR_W-1:0] cfg_sum_thr,
  output logic             busy,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [POS_W-1:0] out_pos,
  output logic [LEN_W-1:0] out_size,
  output logic             out_split,
  output logic             out_last,
  output logic             out_trunc,
  output logic [TAG_W-1:0] out_frame
);
  import cf_pkg::*;

  cf_state_e        state;
  logic [IDX_W-1:0] scan_idx;
  logic [TAG_W-1:0] tag_cnt, cur_tag;
  logic [CNT_W-1:0] kept_cnt;
  logic             drop_flag;

  // Named internal events
  logic             out_free, frame_take, step, last_step;
  logic             rec_take, keep, push_out, flush_out;

  logic [1:0]       code;
  logic             close, split;
  logic [IDX_W-1:0] c_start;
  logic [LEN_W-1:0] c_len;
  logic [SW_W-1:0]  c_sumw;
  logic [SWK_W-1:0] c_sumwk;
  logic             c_seed, c_high, accept;
  logic [POS_W-1:0] new_pos;

  // Single pending record, held until its successor or the frame end is known
  logic             pend_valid;
  logic [POS_W-1:0] pend_pos;
  logic [LEN_W-1:0] pend_size;
  logic             pend_split;

  assign out_free   = !out_valid || out_ready;
  assign frame_take = (state == ST_IDLE) && frame_start;
  assign step       = (state == ST_SCAN) && out_free;
  assign last_step  = step && (scan_idx == IDX_W'(NCH));
  assign rec_take   = close && accept;
  assign keep       = rec_take && (kept_cnt < CNT_W'(MAX_CL));
  assign push_out   = keep && pend_valid;
  assign flush_out  = (state == ST_FLUSH) && pend_valid && out_free;
  assign busy       = (state != ST_IDLE);

  cf_frame_store #(.NCH(NCH), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .load(frame_take), .din(frame_data),
    .rd_idx(scan_idx), .rd_code(code)
  );

  cf_run_accum #(
    .IDX_W(IDX_W), .WGT_W(WGT_W), .MAX_SIZE(MAX_SIZE),
    .LEN_W(LEN_W), .SW_W(SW_W), .SWK_W(SWK_W)
  ) u_accum (
    .clk(clk), .rst_n(rst_n), .step(step), .code(code), .idx(scan_idx),
    .w_nbr(cfg_w_nbr), .w_seed(cfg_w_seed), .w_high(cfg_w_high),
    .close(close), .split(split), .c_start(c_start), .c_len(c_len),
    .c_sumw(c_sumw), .c_sumwk(c_sumwk), .c_seed(c_seed), .c_high(c_high)
  );

  cf_judge #(
    .CH_W(CH_W), .IDX_W(IDX_W), .SW_W(SW_W), .SWK_W(SWK_W),
    .THR_W(THR_W), .POS_W(POS_W)
  ) u_judge (
    .c_start(c_start), .c_sumw(c_sumw), .c_sumwk(c_sumwk),
    .c_seed(c_seed), .c_high(c_high), .thr(cfg_sum_thr),
    .accept(accept), .pos(new_pos)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      scan_idx <= '0;
      tag_cnt  <= '0;
      cur_tag  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (frame_start) begin
          state    <= ST_SCAN;
          scan_idx <= '0;
          cur_tag  <= tag_cnt;
          tag_cnt  <= tag_cnt + TAG_W'(1);
        end
        ST_SCAN: if (step) begin
          if (last_step) state <= ST_FLUSH;
          else           scan_idx <= scan_idx + IDX_W'(1);
        end
        ST_FLUSH: if (!pend_valid || out_free) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kept_cnt  <= '0;
      drop_flag <= 1'b0;
    end else if (frame_take) begin
      kept_cnt  <= '0;
      drop_flag <= 1'b0;
    end else if (keep) begin
      kept_cnt  <= kept_cnt + CNT_W'(1);
    end else if (rec_take) begin
      drop_flag <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      pend_pos   <= '0;
      pend_size  <= '0;
      pend_split <= 1'b0;
    end else if (keep) begin
      pend_valid <= 1'b1;
      pend_pos   <= new_pos;
      pend_size  <= c_len;
      pend_split <= split;
    end else if (flush_out) begin
      pend_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pos   <= '0;
      out_size  <= '0;
      out_split <= 1'b0;
      out_last  <= 1'b0;
      out_trunc <= 1'b0;
      out_frame <= '0;
    end else if (push_out || flush_out) begin
      out_valid <= 1'b1;
      out_pos   <= pend_pos;
      out_size  <= pend_size;
      out_split <= pend_split;
      out_last  <= flush_out;
      out_trunc <= flush_out && drop_flag;
      out_frame <= cur_tag;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/cluster_finder_sva.sv
module cluster_finder_sva #(
  parameter int POS_W    = 9,
  parameter int LEN_W    = 3,
  parameter int TAG_W    = 8,
  parameter int MAX_SIZE = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             out_valid,
  input logic             out_ready,
  input logic [POS_W-1:0] out_pos,
  input logic [LEN_W-1:0] out_size,
  input logic             out_split,
  input logic             out_last,
  input logic             out_trunc,
  input logic [TAG_W-1:0] out_frame,
  input logic             busy,
  input logic             frame_start,
  input logic             frame_take,
  input logic [TAG_W-1:0] tag_cnt
);
  p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_pos) && $stable(out_size)
      && $stable(out_split) && $stable(out_last) && $stable(out_trunc) && $stable(out_frame));

  p_size_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_size != '0) && (out_size <= LEN_W'(MAX_SIZE)));

  p_split_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_split |-> out_size == LEN_W'(MAX_SIZE));

  p_trunc_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_trunc |-> out_last);

  p_tag_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_take |=> tag_cnt == TAG_W'($past(tag_cnt) + 1'b1));

  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && frame_start |=> $stable(tag_cnt));
endmodule

bind cluster_finder cluster_finder_sva #(
  .POS_W(POS_W), .LEN_W(LEN_W), .TAG_W(TAG_W), .MAX_SIZE(MAX_SIZE)
) u_sva (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_pos(out_pos), .out_size(out_size), .out_split(out_split),
  .out_last(out_last), .out_trunc(out_trunc), .out_frame(out_frame),
  .busy(busy), .frame_start(frame_start), .frame_take(frame_take),
  .tag_cnt(tag_cnt)
);

// File: tb/cluster_finder_test.sv
module cluster_finder_test;
  localparam int NCH = 128;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rst_n;
  logic             frame_start;
  logic [2*NCH-1:0] frame_data;
  logic [3:0]       cfg_w_nbr, cfg_w_seed, cfg_w_high;
  logic [7:0]       cfg_sum_thr;
  logic             busy, out_valid, out_ready;
  logic [8:0]       out_pos;
  logic [2:0]       out_size;
  logic             out_split, out_last, out_trunc;
  logic [7:0]       out_frame;

  cluster_finder uut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_data(frame_data),
    .cfg_w_nbr(cfg_w_nbr), .cfg_w_seed(cfg_w_seed), .cfg_w_high(cfg_w_high),
    .cfg_sum_thr(cfg_sum_thr), .busy(busy), .out_valid(out_valid),
    .out_ready(out_ready), .out_pos(out_pos), .out_size(out_size),
    .out_split(out_split), .out_last(out_last), .out_trunc(out_trunc),
    .out_frame(out_frame)
  );

  int n_checks = 0;
  int n_err    = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected and received record lists
  int e_pos[64], e_size[64], e_split[64];
  int e_n;
  bit e_drop;
  int g_pos[64], g_size[64], g_split[64], g_last[64], g_trunc[64], g_tag[64];
  int g_n;
  int exp_tag = 0;
  logic [31:0] rs = 32'h1CE4_E5B9;

  task automatic rnd(output int v);
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 17);
    rs = rs ^ (rs << 5);
    v  = int'(rs[30:0]);
  endtask

  function automatic int wt(input logic [1:0] c);
    case (c)
      2'b01:   return int'(cfg_w_nbr);
      2'b10:   return int'(cfg_w_seed);
      2'b11:   return int'(cfg_w_high);
      default: return 0;
    endcase
  endfunction

  function automatic logic [2*NCH-1:0] put(input logic [2*NCH-1:0] d, input int i,
                                           input logic [1:0] c);
    d[2*i +: 2] = c;
    return d;
  endfunction

  // Reference list: runs of non-zero codes, cut into pieces of at most 4
  task automatic model(input logic [2*NCH-1:0] d);
    int i, j, c, len, sw, swi, seed, high, k;
    e_n = 0; e_drop = 0; i = 0;
    while (i < NCH) begin
      if (d[2*i +: 2] == 2'b00) begin
        i++;
      end else begin
        j = i;
        while (j < NCH && d[2*j +: 2] != 2'b00) j++;
        for (c = i; c < j; c += 4) begin
          len = (j - c < 4) ? j - c : 4;
          sw = 0; swi = 0; seed = 0; high = 0;
          for (k = c; k < c + len; k++) begin
            sw  += wt(d[2*k +: 2]);
            swi += wt(d[2*k +: 2]) * k;
            if (d[2*k+1]) seed = 1;
            if (d[2*k +: 2] == 2'b11) high = 1;
          end
          if (high != 0 || (seed != 0 && sw > int'(cfg_sum_thr))) begin
            if (e_n < 16) begin
              e_pos[e_n]   = (sw == 0) ? 4 * c : (4 * swi) / sw;
              e_size[e_n]  = len;
              e_split[e_n] = (c + 4 < j) ? 1 : 0;
              e_n++;
            end else begin
              e_drop = 1;
            end
          end
        end
        i = j;
      end
    end
  endtask

  task automatic run_frame(input logic [2*NCH-1:0] d, input int mode, input bit inject,
                           input logic [2*NCH-1:0] d2, input string tag);
    int cyc, v, k, lim;
    model(d);
    while (busy) @(negedge clk);
    frame_data  = d;
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    g_n = 0; cyc = 0;
    while ((busy || out_valid) && cyc < 5000) begin
      rnd(v);
      case (mode)
        0:       out_ready = 1'b1;
        1:       out_ready = (v % 4) != 0;
        default: out_ready = (v % 4) == 0;
      endcase
      if (inject && cyc == 3) begin
        frame_start = 1'b1;
        frame_data  = d2;
      end else begin
        frame_start = 1'b0;
      end
      if (out_valid && out_ready && g_n < 64) begin
        g_pos[g_n]   = int'(out_pos);
        g_size[g_n]  = int'(out_size);
        g_split[g_n] = int'(out_split);
        g_last[g_n]  = int'(out_last);
        g_trunc[g_n] = int'(out_trunc);
        g_tag[g_n]   = int'(out_frame);
        g_n++;
      end
      @(negedge clk);
      cyc++;
    end
    frame_start = 1'b0;
    chk(cyc < 5000, {"R10 frame drains ", tag}, cyc, 5000);
    chk(g_n == e_n, {"R2/R3/R7 record count ", tag}, g_n, e_n);
    lim = (g_n < e_n) ? g_n : e_n;
    for (k = 0; k < lim; k++) begin
      chk(g_pos[k] == e_pos[k], {"R5 position ", tag}, g_pos[k], e_pos[k]);
      chk(g_size[k] == e_size[k], {"R6 size ", tag}, g_size[k], e_size[k]);
      chk(g_split[k] == e_split[k], {"R6 split flag ", tag}, g_split[k], e_split[k]);
      chk(g_tag[k] == exp_tag, {"R8 frame tag ", tag}, g_tag[k], exp_tag);
      chk(g_last[k] == ((k == e_n - 1) ? 1 : 0), {"R7 last flag ", tag}, g_last[k],
          (k == e_n - 1) ? 1 : 0);
      chk(g_trunc[k] == ((k == e_n - 1 && e_drop) ? 1 : 0), {"R7 trunc flag ", tag},
          g_trunc[k], (k == e_n - 1 && e_drop) ? 1 : 0);
    end
    exp_tag = (exp_tag + 1) % 256;
  endtask

  initial begin
    #(200000 * 20);
    n_err++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", n_checks, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_checks + 1);
    $finish;
  end

  initial begin
    logic [2*NCH-1:0] d;
    int v, c;
    rst_n = 1'b0; frame_start = 1'b0; frame_data = '0; out_ready = 1'b0;
    cfg_w_nbr = 4'd1; cfg_w_seed = 4'd2; cfg_w_high = 4'd3; cfg_sum_thr = 8'd3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
    chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);

    // R2: empty frame gives nothing
    run_frame('0, 0, 1'b0, '0, "empty");

    // R4 edges, R3 neighbour-only runs rejected
    d = '0;
    d = put(d, 0, 2'b11); d = put(d, 127, 2'b11);
    d = put(d, 60, 2'b01); d = put(d, 62, 2'b01); d = put(d, 63, 2'b01);
    run_frame(d, 0, 1'b0, '0, "edges");

    // R3 threshold strictness, R5 fractional position
    d = '0;
    d = put(d, 10, 2'b10); d = put(d, 11, 2'b01);
    d = put(d, 19, 2'b01); d = put(d, 20, 2'b10); d = put(d, 21, 2'b01);
    d = put(d, 30, 2'b10); d = put(d, 31, 2'b10);
    d = put(d, 40, 2'b01); d = put(d, 41, 2'b10); d = put(d, 42, 2'b11);
    run_frame(d, 1, 1'b0, '0, "threshold");

    // R6 long runs, R4 run touching channel 127
    d = '0;
    for (int k = 40; k < 50; k++) d = put(d, k, 2'b10);
    for (int k = 70; k < 78; k++) d = put(d, k, 2'b01);
    d = put(d, 126, 2'b10); d = put(d, 127, 2'b10);
    run_frame(d, 2, 1'b0, '0, "split");

    // R5 zero weights
    cfg_w_nbr = 4'd0; cfg_w_seed = 4'd0; cfg_w_high = 4'd0; cfg_sum_thr = 8'd0;
    d = '0;
    d = put(d, 5, 2'b11); d = put(d, 8, 2'b11); d = put(d, 9, 2'b01);
    run_frame(d, 0, 1'b0, '0, "zero weights");
    cfg_w_nbr = 4'd1; cfg_w_seed = 4'd2; cfg_w_high = 4'd3; cfg_sum_thr = 8'd3;

    // R7 cap: 64 isolated highs, then exactly 16
    d = '0;
    for (int k = 0; k < NCH; k += 2) d = put(d, k, 2'b11);
    run_frame(d, 1, 1'b0, '0, "cap over");
    d = '0;
    for (int k = 0; k < NCH; k += 8) d = put(d, k, 2'b11);
    run_frame(d, 2, 1'b0, '0, "cap exact");

    // R9 frame_start while busy ignored
    d = '0;
    d = put(d, 50, 2'b11);
    run_frame(d, 2, 1'b1, {NCH{2'b11}}, "busy ignore");
    run_frame(put('0, 90, 2'b11), 0, 1'b0, '0, "after ignore");

    // sweep: random weights, thresholds, densities, ready patterns
    for (int f = 0; f < 60; f++) begin
      rnd(v); cfg_w_nbr  = 4'(v);
      rnd(v); cfg_w_seed = 4'(v);
      rnd(v); cfg_w_high = 4'(v);
      rnd(v); cfg_sum_thr = 8'(v % 24);
      rnd(c); c = 3 + (c % 6);
      d = '0;
      for (int k = 0; k < NCH; k++) begin
        rnd(v);
        if ((v % 10) < c) d = put(d, k, 2'(1 + (v / 10) % 3));
      end
      run_frame(d, f % 3, 1'b0, '0, "sweep");
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule